// File: doc/BRIEF.md
# Iterative Factorial Coprocessor

This block is a small memory-mapped coprocessor that computes the factorial of a 32-bit operand. Software stores the operand into a shared operand/result register, which starts a loop that performs one multiplication per clock against a down-counter. While the loop runs, a busy flag in the status register stays high. When the loop finishes, the product replaces the operand in the same register and the busy flag drops.

Software can arm a completion interrupt by setting an enable flag in the status register. The unit checks that flag only after busy has already cleared. If the flag is set, a single-cycle done request appears on the interrupt output. The register port is a plain write strobe with an address and write data. Read data comes from the address combinationally, so software can poll busy at any time. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `fact_unit`

## Requirements
- R1: After reset, busy and the interrupt enable read as 0, the operand/result register (offset 0x08) reads 0, and `irq_done` is low.
- R2: A write to offset 0x08 while idle loads the operand. Status bit 0 (busy) reads 1 from the cycle after the write edge.
- R3: At completion, offset 0x08 holds n·(n-1)·…·1 modulo 2^32. Operands 0 and 1 both give 1.
- R4: Busy stays high for exactly max(n,1) clock cycles after the write edge, because each cycle performs one multiply step.
- R5: A write to offset 0x08 while busy is discarded. Neither the final result nor the completion cycle changes.
- R6: Reading offset 0x08 while busy returns the loaded operand, never a partial product.
- R7: A write to the status register (offset 0x20) changes only bit 7 (interrupt enable). Writing 1 to any other bit has no effect.
- R8: When the enable is set, `irq_done` is high for exactly one cycle, namely the first cycle in which busy reads 0 after a computation. It is never high while busy is set.
- R9: When the enable reads 0 at completion, `irq_done` stays low.
- R10: A read of any address other than 0x08 or 0x20 returns 0. A write to such an address changes no state.
- R11: The status register reads busy in bit 0, the enable in bit 7, and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_done | output | 1 | One-cycle completion interrupt request |

## Verification
A counter that steps wrongly shows up in two places. The busy bit falls on the wrong cycle, and because every step multiplies by the count, the read-back result is also wrong. Both are visible within n cycles of the start. The bench therefore sweeps the operand from 0 upward and checks busy on every cycle, not just at the end. A corrupted enable or done flag appears as a missing, early, doubled or unwanted pulse on `irq_done` in the cycle after busy falls. A protection fault shows up as an operand that changes while busy, or as a final value or completion time that shifts after a write made during busy.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam logic [7:0] OFS_DATA = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_IEN_BIT  = 7;
endpackage

// File: rtl/fact_engine.sv
module fact_engine #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] operand,
  output logic         busy,
  output logic         finish,
  output logic [W-1:0] result,
  output logic         done_q
);
  logic         busy_q, busy_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] acc_q, acc_d;
  logic         done_d;
  logic         last;

  assign last   = (cnt_q <= W'(1));
  assign finish = busy_q & last;
  assign result = acc_q;
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = operand;
        acc_d  = W'(1);
      end
    end else if (last) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      acc_d = acc_q * cnt_q;
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      acc_q  <= acc_d;
      done_q <= done_d;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q);  // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) - W'(1)));  // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R8
endmodule

// File: rtl/fact_regs.sv
module fact_regs
  import fact_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              busy,
  input  logic              finish,
  input  logic [W-1:0]      result,
  input  logic              done_q,
  output logic              start,
  output logic [W-1:0]      operand,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [W-1:0] data_q, data_d;
  logic         ien_q, ien_d;
  logic         hit_data, hit_stat;
  logic [W-1:0] stat_word;

  assign hit_data = (bus_addr == A_DATA);
  assign hit_stat = (bus_addr == A_STAT);
  assign start    = bus_wr & hit_data & ~busy;
  assign operand  = bus_wdata;

  always_comb begin
    data_d = data_q;
    if (finish)     data_d = result;
    else if (start) data_d = bus_wdata;
  end

  always_comb begin
    ien_d = ien_q;
    if (bus_wr && hit_stat) ien_d = bus_wdata[STAT_IEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    stat_word                = '0;
    stat_word[STAT_BUSY_BIT] = busy;
    stat_word[STAT_IEN_BIT]  = ien_q;
  end

  always_comb begin
    if (hit_data)      bus_rdata = data_q;
    else if (hit_stat) bus_rdata = stat_word;
    else               bus_rdata = '0;
  end

  assign irq = done_q & ien_q;

  AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> $stable(data_q));  // R5
  AST_NO_IRQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq);  // R8
  AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(busy) && !busy));  // R8
  AST_STATUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stat |-> ((bus_rdata & ~(W'(1) << STAT_BUSY_BIT) & ~(W'(1) << STAT_IEN_BIT)) == '0));  // R11
endmodule

// File: rtl/fact_unit.sv
module fact_unit #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_done
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              start, busy, finish, done_q;
  logic [DATA_W-1:0] operand, result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fact_regs #(.ADDR_W(ADDR_W), .W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .busy(busy), .finish(finish), .result(result), .done_q(done_q),
    .start(start), .operand(operand), .irq(irq_done)
  );

  fact_engine #(.W(DATA_W)) u_engine (
    .clk(clk), .rst_n(rst_int_n),
    .start(start), .operand(operand),
    .busy(busy), .finish(finish), .result(result), .done_q(done_q)
  );

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_done |=> !irq_done);  // R8
endmodule

// File: tb/fact_unit_test.sv
module fact_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_done;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  fact_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_done(irq_done)
  );

  function automatic logic [31:0] fact_ref(input int n);
    logic [31:0] p = 32'd1;
    for (int i = 2; i <= n; i++) p = p * 32'(i);
    return p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Start factorial of n; optionally poke 0x08 with junk in cycle poke_at.
  task automatic run_fact(input int n, input bit en, input int poke_at);
    logic [31:0] d;
    int len = (n < 1) ? 1 : n;
    wr(8'h20, {24'h0, en, 7'h0});
    wr(8'h08, 32'(n));
    peek(8'h20, d);
    chk(d[0] == 1'b1, "R2 busy after load", d, 32'h1);
    peek(8'h08, d);
    chk(d == 32'(n), "R6 operand held while busy", d, 32'(n));
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      peek(8'h20, d);
      chk(d[0] == (k < len), "R4 busy duration", {31'h0, d[0]}, {31'h0, k < len});
      chk(irq_done == (k == len && en), (en ? "R8 irq timing" : "R9 irq masked"),
          {31'h0, irq_done}, {31'h0, k == len && en});
      if (k < len) begin
        peek(8'h08, d);
        chk(d == 32'(n), "R6 no partial product", d, 32'(n));
      end
      if (k == poke_at && k < len) begin
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h3;
      end
    end
    peek(8'h08, d);
    chk(d == fact_ref(n), (poke_at > 0 ? "R5 result after ignored write" : "R3 result"), d, fact_ref(n));
    @(negedge clk);
    chk(irq_done == 1'b0, "R8 irq single cycle", {31'h0, irq_done}, 32'h0);
  endtask

  initial begin
    int cyc = 0;
    while (!done_flag) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    peek(8'h20, d); chk(d == 32'h0, "R1 status reset", d, 32'h0);
    peek(8'h08, d); chk(d == 32'h0, "R1 data reset", d, 32'h0);
    chk(irq_done == 1'b0, "R1 irq reset", {31'h0, irq_done}, 32'h0);

    // R7 / R11: only bit 7 writable, busy not settable
    wr(8'h20, 32'hFFFF_FF7F);
    peek(8'h20, d); chk(d == 32'h0, "R7 other status bits ignored", d, 32'h0);
    wr(8'h20, 32'hFFFF_FFFF);
    peek(8'h20, d); chk(d == 32'h80, "R11 status layout", d, 32'h80);
    wr(8'h20, 32'h0);

    // R10: unmapped addresses
    wr(8'h0C, 32'hDEAD_BEEF);
    peek(8'h0C, d); chk(d == 32'h0, "R10 unmapped read", d, 32'h0);
    peek(8'h08, d); chk(d == 32'h0, "R10 unmapped write no effect", d, 32'h0);
    peek(8'h20, d); chk(d == 32'h0, "R10 unmapped write no start", d, 32'h0);

    // Sweep operands with alternating interrupt enable
    for (int n = 0; n <= 40; n++) run_fact(n, n[0], 0);

    // R5: writes during busy are discarded
    run_fact(6, 1'b1, 2);
    run_fact(9, 1'b0, 1);
    run_fact(12, 1'b1, 11);

    done_flag = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule